// File: doc/BRIEF.md
# Operand Forwarding Control for a Four-Stage Pipeline

This block decides, for each of the two ALU operands of the instruction now in the register-read stage, whether the value read from the register file is current or whether a newer value is still in flight. An older instruction may be one stage ahead in the ALU stage with its result not yet written. It may also be two stages ahead in write-back, with the write happening this cycle. The block compares the source register fields of the register-read instruction against the destinations of those older instructions. From that it produces a 2-bit select per operand, and it steers the chosen value into the ALU-stage operand registers.

The two forwarding sources are qualified differently. The ALU-stage source is trusted by instruction class: an operate instruction there will write its `rc` field. The write-back source is trusted only through the actual register-file write enable and write address presented in that cycle. With forwarding in place, a chain of dependent operate instructions issued back to back gets correct operands without any stall. Without forwarding, the consumer directly after its producer would read a stale register. Load-use stalls and branch annulment are handled elsewhere.

The instruction word has a 6-bit opcode in bits [31:26], the destination `rc` in [25:21], source `ra` in [20:16] and source `rb` in [15:11]. Opcodes whose two top bits are `10` are register-operate; opcodes whose two top bits are `11` are literal-operate, whose bits [15:0] hold a constant. Every other opcode is a non-operate instruction. Register 31 always reads as zero.

Top module: `opfwd_unit`

## Requirements
- R1: Select codes are 0 = register file, 1 = ALU-stage result, 2 = write-back data, and code 3 never appears. Operand A selects 1 when the register-read instruction is register-operate or literal-operate, the ALU-stage instruction is operate of either kind, and its `ra` equals the ALU-stage `rc`.
- R2: Operand B selects 1 when the register-read instruction is register-operate, the ALU-stage instruction is operate of either kind, and its `rb` equals the ALU-stage `rc`.
- R3: Operand A selects 2 when the register-read instruction is operate of either kind, `wb_we` is 1, its `ra` equals `wb_wa`, and R1 does not apply.
- R4: Operand B selects 2 when the register-read instruction is register-operate, `wb_we` is 1, its `rb` equals `wb_wa`, and R2 does not apply.
- R5: When a source register matches both the ALU-stage `rc` and the write-back address, the select is 1.
- R6: A source register field equal to 31 always gives select 0 for that operand.
- R7: When the register-read instruction is literal-operate, operand B selects 0 whatever the stage destinations are.
- R8: When the register-read instruction is not an operate instruction, both selects are 0.
- R9: When the ALU-stage instruction is not an operate instruction, its `rc` causes no select of 1.
- R10: With `wb_we` at 0, no select of 2 appears.
- R11: On each rising clock edge, `opnd_a` and `opnd_b` take the value chosen by `sel_a` and `sel_b`: `rf_rd1`/`rf_rd2` for select 0, `alu_y` for select 1, `wb_wd` for select 2. A synchronous low `rst_n` clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rf_insn | input | 32 | Instruction in the register-read stage |
| rf_rd1 | input | DATA_W | Register-file value read for `ra` |
| rf_rd2 | input | DATA_W | Register-file value read for `rb` |
| alu_insn | input | 32 | Instruction in the ALU stage |
| alu_y | input | DATA_W | Result the ALU is producing this cycle |
| wb_we | input | 1 | Register-file write enable in write-back |
| wb_wa | input | 5 | Register-file write address in write-back |
| wb_wd | input | DATA_W | Register-file write data in write-back |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DATA_W | Registered operand A for the ALU stage |
| opnd_b | output | DATA_W | Registered operand B for the ALU stage |

## Verification
Two things can happen in the same cycle: a source register can match the ALU-stage destination and the write-back address together, and both operands can be forwarded at once. The bench provokes the first by giving both older stages the same destination as `ra` and `rb`, so the newer result must win. It provokes the second by making both sources the same register. Each such cycle is judged twice. The selects are checked right after the inputs settle. Once that cycle's rising edge has passed, a scoreboard entry holding the value the registered operands must hold is compared against `opnd_a` and `opnd_b`.

// File: rtl/opfwd_pkg.sv
// Shared encodings for the operand forwarding control.
// Assumes the fixed instruction layout: opcode [31:26], rc [25:21],
// ra [20:16], rb [15:11]; register 31 is the hard-wired zero register.
package opfwd_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_AW  = 5;
    localparam int OPC_LO  = 26;
    localparam int RC_LO   = 21;
    localparam int RA_LO   = 16;
    localparam int RB_LO   = 11;
    localparam logic [REG_AW-1:0] ZERO_REG = '1;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_ALU = 2'd1,
        SRC_WB  = 2'd2
    } fwd_src_e;

    // Register-operate class: top two opcode bits are 10.
    function automatic logic is_reg_op(input logic [OPC_W-1:0] opc);
        return opc[OPC_W-1 -: 2] == 2'b10;
    endfunction

    // Literal-operate class: top two opcode bits are 11.
    function automatic logic is_lit_op(input logic [OPC_W-1:0] opc);
        return opc[OPC_W-1 -: 2] == 2'b11;
    endfunction

endpackage

// File: rtl/opfwd_match.sv
// Compares one source register against the two in-flight destinations.
// USE_B selects the operand-B rule, where only register-operate
// consumers take part, because a literal-operate consumer uses a constant.
// Assumes the caller has already decoded the instruction classes.
module opfwd_match
    import opfwd_pkg::*;
#(
    parameter bit USE_B = 1'b0
) (
    input  logic [REG_AW-1:0] src_reg,
    input  logic              rf_reg_op,
    input  logic              rf_lit_op,
    input  logic              alu_is_op,
    input  logic [REG_AW-1:0] alu_rc,
    input  logic              wb_we,
    input  logic [REG_AW-1:0] wb_wa,
    output logic              hit_alu,
    output logic              hit_wb
);

    logic eligible;

    // Decide whether this consumer reads its register for this operand.
    always_comb begin
        if (USE_B) eligible = rf_reg_op;
        else       eligible = rf_reg_op | rf_lit_op;
    end

    // Raise a hit per source; the zero register never forwards.
    always_comb begin
        hit_alu = eligible && (src_reg != ZERO_REG) && alu_is_op && (src_reg == alu_rc);
        hit_wb  = eligible && (src_reg != ZERO_REG) && wb_we && (src_reg == wb_wa);
    end

endmodule

// File: rtl/opfwd_prio.sv
// Turns the two hit flags into a select code; the younger ALU-stage
// value outranks the older write-back value. Assumes hits are pre-qualified.
module opfwd_prio
    import opfwd_pkg::*;
(
    input  logic     hit_alu,
    input  logic     hit_wb,
    output fwd_src_e sel
);

    // Priority pick: ALU stage, then write-back, then the register file.
    always_comb begin
        if (hit_alu)     sel = SRC_ALU;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_RF;
    end

endmodule

// File: rtl/opfwd_mux.sv
// Three-way operand multiplexer driven by a forwarding select.
// Assumes sel only carries the three defined codes.
module opfwd_mux
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_src_e          sel,
    input  logic [DATA_W-1:0] from_rf,
    input  logic [DATA_W-1:0] from_alu,
    input  logic [DATA_W-1:0] from_wb,
    output logic [DATA_W-1:0] dout
);

    // Route the selected source to the output.
    always_comb begin
        unique case (sel)
            SRC_ALU: dout = from_alu;
            SRC_WB:  dout = from_wb;
            default: dout = from_rf;
        endcase
    end

endmodule

// File: rtl/opfwd_unit.sv
// Operand forwarding control for a four-stage pipeline, plus the operand
// muxes and the ALU-stage operand registers they feed.
// Assumes the ALU-stage instruction writes its rc exactly when it is an
// operate instruction, and that wb_we/wb_wa describe the write this cycle.
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] rf_insn,
    input  logic [DATA_W-1:0] rf_rd1,
    input  logic [DATA_W-1:0] rf_rd2,
    input  logic [INSN_W-1:0] alu_insn,
    input  logic [DATA_W-1:0] alu_y,
    input  logic              wb_we,
    input  logic [REG_AW-1:0] wb_wa,
    input  logic [DATA_W-1:0] wb_wd,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int NUM_OPND = 2;

    logic [OPC_W-1:0]  rf_opc;
    logic [OPC_W-1:0]  alu_opc;
    logic [REG_AW-1:0] alu_rc;
    logic              rf_reg_op;
    logic              rf_lit_op;
    logic              alu_is_op;

    logic [REG_AW-1:0] src_reg [NUM_OPND];
    logic [DATA_W-1:0] rd_val  [NUM_OPND];
    logic [DATA_W-1:0] opnd_d  [NUM_OPND];
    logic [DATA_W-1:0] opnd_q  [NUM_OPND];
    fwd_src_e          sel_v   [NUM_OPND];

    logic unused_insn_bits;

    // Pull the fields this block needs out of both instruction words.
    always_comb begin
        rf_opc     = rf_insn[OPC_LO +: OPC_W];
        alu_opc    = alu_insn[OPC_LO +: OPC_W];
        alu_rc     = alu_insn[RC_LO +: REG_AW];
        src_reg[0] = rf_insn[RA_LO +: REG_AW];
        src_reg[1] = rf_insn[RB_LO +: REG_AW];
        rd_val[0]  = rf_rd1;
        rd_val[1]  = rf_rd2;
        rf_reg_op  = is_reg_op(rf_opc);
        rf_lit_op  = is_lit_op(rf_opc);
        alu_is_op  = is_reg_op(alu_opc) | is_lit_op(alu_opc);
    end

    // Mark the instruction bits that carry no forwarding information.
    assign unused_insn_bits = ^{rf_insn[RC_LO +: REG_AW], rf_insn[RB_LO-1:0],
                                alu_insn[RC_LO-1:0]};

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        logic hit_alu;
        logic hit_wb;

        opfwd_match #(
            .USE_B (k == 1)
        ) u_match (
            .src_reg   (src_reg[k]),
            .rf_reg_op (rf_reg_op),
            .rf_lit_op (rf_lit_op),
            .alu_is_op (alu_is_op),
            .alu_rc    (alu_rc),
            .wb_we     (wb_we),
            .wb_wa     (wb_wa),
            .hit_alu   (hit_alu),
            .hit_wb    (hit_wb)
        );

        opfwd_prio u_prio (
            .hit_alu (hit_alu),
            .hit_wb  (hit_wb),
            .sel     (sel_v[k])
        );

        opfwd_mux #(
            .DATA_W (DATA_W)
        ) u_mux (
            .sel      (sel_v[k]),
            .from_rf  (rd_val[k]),
            .from_alu (alu_y),
            .from_wb  (wb_wd),
            .dout     (opnd_d[k])
        );

        // Capture the chosen operand for the ALU stage.
        always_ff @(posedge clk) begin
            if (!rst_n) opnd_q[k] <= '0;
            else        opnd_q[k] <= opnd_d[k];
        end
    end

    // Drive the output ports from the per-operand arrays.
    always_comb begin
        sel_a  = sel_v[0];
        sel_b  = sel_v[1];
        opnd_a = opnd_q[0];
        opnd_b = opnd_q[1];
    end

endmodule

// File: rtl/opfwd_unit_chk.sv
// Property checker for opfwd_unit, bound to every instance of it.
// Decodes the instruction fields on its own from the fixed layout.
module opfwd_unit_chk
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [INSN_W-1:0] rf_insn,
    input logic [DATA_W-1:0] rf_rd1,
    input logic [DATA_W-1:0] rf_rd2,
    input logic [INSN_W-1:0] alu_insn,
    input logic [DATA_W-1:0] alu_y,
    input logic              wb_we,
    input logic [REG_AW-1:0] wb_wa,
    input logic [DATA_W-1:0] wb_wd,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);

    logic [OPC_W-1:0]  c_rf_opc;
    logic [OPC_W-1:0]  c_alu_opc;
    logic [REG_AW-1:0] c_ra;
    logic [REG_AW-1:0] c_rb;
    logic [REG_AW-1:0] c_rc;
    logic              c_rf_any_op;
    logic              c_alu_any_op;

    // Independent decode of the fields the properties refer to.
    always_comb begin
        c_rf_opc     = rf_insn[INSN_W-1 -: OPC_W];
        c_alu_opc    = alu_insn[INSN_W-1 -: OPC_W];
        c_ra         = rf_insn[20:16];
        c_rb         = rf_insn[15:11];
        c_rc         = alu_insn[25:21];
        c_rf_any_op  = c_rf_opc[OPC_W-1];
        c_alu_any_op = c_alu_opc[OPC_W-1];
    end

    assert_enc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'd3) && (sel_b != 2'd3));

    assert_alu_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'd1) |=> (opnd_a == $past(alu_y)));

    assert_alu_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 2'd1) |=> (opnd_b == $past(alu_y)));

    assert_wb_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'd2) |=> (opnd_a == $past(wb_wd)));

    assert_wb_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 2'd2) |=> (opnd_b == $past(wb_wd)));

    assert_newer_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rf_any_op && c_alu_any_op && c_ra != 5'd31 && c_ra == c_rc)
        |-> (sel_a == 2'd1));

    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_ra == 5'd31) |-> (sel_a == 2'd0)) and ((c_rb == 5'd31) |-> (sel_b == 2'd0)));

    assert_literal_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rf_opc[OPC_W-1 -: 2] == 2'b11) |-> (sel_b == 2'd0));

    assert_non_operate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rf_any_op |-> (sel_a == 2'd0 && sel_b == 2'd0));

    assert_alu_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !c_alu_any_op |-> (sel_a != 2'd1 && sel_b != 2'd1));

    assert_no_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_we |-> (sel_a != 2'd2 && sel_b != 2'd2));

    assert_rf_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'd0 && sel_b == 2'd0) |=> (opnd_a == $past(rf_rd1) && opnd_b == $past(rf_rd2)));

endmodule

bind opfwd_unit opfwd_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_opfwd_unit.sv
module tb_opfwd_unit;

    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       rf_insn = '0;
    logic [DATA_W-1:0] rf_rd1 = '0;
    logic [DATA_W-1:0] rf_rd2 = '0;
    logic [31:0]       alu_insn = '0;
    logic [DATA_W-1:0] alu_y = '0;
    logic              wb_we = 1'b0;
    logic [4:0]        wb_wa = '0;
    logic [DATA_W-1:0] wb_wd = '0;
    logic [1:0]        sel_a;
    logic [1:0]        sel_b;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] exp_a;
        logic [DATA_W-1:0] exp_b;
        string             tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    localparam logic [5:0] OPC_REG  = 6'h20;
    localparam logic [5:0] OPC_LIT  = 6'h30;
    localparam logic [5:0] OPC_LOAD = 6'h18;

    opfwd_unit #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .rf_insn(rf_insn), .rf_rd1(rf_rd1), .rf_rd2(rf_rd2),
        .alu_insn(alu_insn), .alu_y(alu_y), .wb_we(wb_we), .wb_wa(wb_wa), .wb_wd(wb_wd),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rc,
                                       input logic [4:0] ra, input logic [4:0] rb);
        return {opc, rc, ra, rb, 11'h0};
    endfunction

    function automatic logic [DATA_W-1:0] pick(input logic [1:0] s, input logic [DATA_W-1:0] rf);
        return (s == 2'd1) ? alu_y : (s == 2'd2) ? wb_wd : rf;
    endfunction

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check selects, queue the operand result.
    task automatic drive(input string tag, input logic [31:0] rfi, input logic [31:0] alui,
                         input logic we, input logic [4:0] wa,
                         input logic [1:0] exp_sa, input logic [1:0] exp_sb);
        sb_item_t it;
        @(negedge clk);
        rf_insn  = rfi;
        alu_insn = alui;
        wb_we    = we;
        wb_wa    = wa;
        rf_rd1   = $urandom;
        rf_rd2   = $urandom;
        alu_y    = $urandom;
        wb_wd    = $urandom;
        #1;
        check({tag, " sel_a"}, {{(DATA_W-2){1'b0}}, sel_a}, {{(DATA_W-2){1'b0}}, exp_sa});
        check({tag, " sel_b"}, {{(DATA_W-2){1'b0}}, sel_b}, {{(DATA_W-2){1'b0}}, exp_sb});
        it.exp_a = pick(exp_sa, rf_rd1);
        it.exp_b = pick(exp_sb, rf_rd2);
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: after each rising edge, compare registered operands with the queue head.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check({it.tag, " R11 opnd_a"}, opnd_a, it.exp_a);
            check({it.tag, " R11 opnd_b"}, opnd_b, it.exp_b);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rf_rd1 = 32'hAAAA_0001;
        rf_rd2 = 32'hBBBB_0002;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset opnd_a", opnd_a, '0);
        check("R11 reset opnd_b", opnd_b, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: ALU-stage match on ra.
        drive("R1 alu fwd a", mk(OPC_REG, 5'd7, 5'd3, 5'd4), mk(OPC_REG, 5'd3, 5'd1, 5'd2), 1'b0, 5'd0, 2'd1, 2'd0);
        // R2: ALU-stage match on rb.
        drive("R2 alu fwd b", mk(OPC_REG, 5'd7, 5'd4, 5'd3), mk(OPC_LIT, 5'd3, 5'd1, 5'd2), 1'b0, 5'd0, 2'd0, 2'd1);
        // R3: write-back match on ra.
        drive("R3 wb fwd a", mk(OPC_REG, 5'd7, 5'd3, 5'd4), mk(OPC_REG, 5'd9, 5'd1, 5'd2), 1'b1, 5'd3, 2'd2, 2'd0);
        // R3: literal-operate consumer still forwards operand A.
        drive("R3 wb fwd a literal", mk(OPC_LIT, 5'd7, 5'd6, 5'd0), mk(OPC_REG, 5'd9, 5'd1, 5'd2), 1'b1, 5'd6, 2'd2, 2'd0);
        // R4: write-back match on rb.
        drive("R4 wb fwd b", mk(OPC_REG, 5'd7, 5'd4, 5'd3), mk(OPC_REG, 5'd9, 5'd1, 5'd2), 1'b1, 5'd3, 2'd0, 2'd2);
        // R5: both stages match both operands; the ALU stage wins.
        drive("R5 priority", mk(OPC_REG, 5'd7, 5'd3, 5'd3), mk(OPC_REG, 5'd3, 5'd1, 5'd2), 1'b1, 5'd3, 2'd1, 2'd1);
        // R5: operand A from ALU stage, operand B from write-back in one cycle.
        drive("R5 mixed sources", mk(OPC_REG, 5'd7, 5'd3, 5'd8), mk(OPC_REG, 5'd3, 5'd1, 5'd2), 1'b1, 5'd8, 2'd1, 2'd2);
        // R6: the zero register never forwards.
        drive("R6 zero reg", mk(OPC_REG, 5'd7, 5'd31, 5'd31), mk(OPC_REG, 5'd31, 5'd1, 5'd2), 1'b1, 5'd31, 2'd0, 2'd0);
        // R7: literal consumer never forwards operand B.
        drive("R7 literal b", mk(OPC_LIT, 5'd7, 5'd5, 5'd5), mk(OPC_REG, 5'd5, 5'd1, 5'd2), 1'b1, 5'd5, 2'd1, 2'd0);
        // R8: non-operate consumer gets no forwarding.
        drive("R8 non-operate", mk(OPC_LOAD, 5'd7, 5'd3, 5'd3), mk(OPC_REG, 5'd3, 5'd1, 5'd2), 1'b1, 5'd3, 2'd0, 2'd0);
        // R9: non-operate ALU-stage instruction falls back to write-back.
        drive("R9 alu non-operate", mk(OPC_REG, 5'd7, 5'd3, 5'd3), mk(OPC_LOAD, 5'd3, 5'd1, 5'd2), 1'b1, 5'd3, 2'd2, 2'd2);
        // R10: write enable low blocks write-back forwarding.
        drive("R10 wb disabled", mk(OPC_REG, 5'd7, 5'd3, 5'd3), mk(OPC_REG, 5'd9, 5'd1, 5'd2), 1'b0, 5'd3, 2'd0, 2'd0);
        // R11: plain register-file path on both operands.
        drive("R11 rf path", mk(OPC_REG, 5'd7, 5'd10, 5'd11), mk(OPC_REG, 5'd12, 5'd1, 5'd2), 1'b1, 5'd13, 2'd0, 2'd0);

        @(posedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule